// File: doc/BRIEF.md
# Overcurrent and Undervoltage Fault Controller

This block guards a three-phase gate-drive stage. It watches three synchronized logic inputs: a digitized overcurrent comparator, a supply-good level that already carries its own hysteresis, and an external enable. From them it makes a single global gate inhibit, which the phase interlock logic uses to force every gate output off. It also makes a fault indication, modelled as the enable of an open-drain pull-down.

An overcurrent trip must stay high for a programmable number of cycles before it is accepted. An accepted trip sets a set-dominant latch. The latch releases only after the trip has gone away and a recovery timer has run its full length. While the trip is present the timer is held at zero, and if the trip returns during recovery the timer starts again from zero.

An undervoltage is not latched. It forces the outputs off and raises the fault indication only for as long as it lasts. The enable has its own symmetric glitch filter. It can inhibit the gates but never raises the fault indication.

Top module: `oc_uv_fault_ctl`

## Requirements
- R1: The trip input is accepted only on the clock edge at which it has been sampled high on `TRIP_FILT_CYC` consecutive edges. A shorter high pulse is ignored and changes neither output. Once the trip is sampled low, acceptance drops on that same edge.
- R2: On the edge after acceptance the overcurrent latch sets, and `gate_inhibit` and `fault_pull_low` read 1. While acceptance is present the latch cannot clear (set dominant).
- R3: While the latch is set and the raw trip is high, the recovery timer stays at zero. It advances by one on each edge where both the raw trip and the accepted trip are low.
- R4: The latch clears on the `CLR_CYC`-th qualifying edge. For a trip held for w ≥ `TRIP_FILT_CYC` cycles, `gate_inhibit` therefore reads 1 for exactly w − `TRIP_FILT_CYC` + `CLR_CYC` cycles.
- R5: A trip that reasserts during recovery, even one too short to be accepted, restarts the timer from zero. The latch then clears `CLR_CYC` edges after the trip falls again.
- R6: `supply_ok` = 0 drives `gate_inhibit` = 1 and `fault_pull_low` = 1 in the same cycle, with no register in the path. Both outputs release in the same cycle when the supply recovers, with nothing latched.
- R7: `fault_pull_low` = 1 (pad driven low) exactly when the overcurrent latch is set or `supply_ok` = 0.
- R8: `enable_in` goes through a symmetric filter of `EN_FILT_CYC` cycles. A low level held for p ≥ `EN_FILT_CYC` cycles holds `gate_inhibit` at 1 for exactly p cycles. Shorter lows are ignored, and the enable never affects `fault_pull_low`.
- R9: Out of reset the latch is clear and the timer is zero. The enable filter starts at 0, so `gate_inhibit` reads 1 until the enable has been accepted and `supply_ok` is 1. Reset is asserted asynchronously and released through two synchronizing flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_in | input | 1 | Synchronized overcurrent comparator output, 1 = over threshold |
| supply_ok | input | 1 | Synchronized low-side supply-good level, 0 = undervoltage |
| enable_in | input | 1 | Synchronized external enable, 0 = force gates off |
| gate_inhibit | output | 1 | 1 = all gate outputs forced off |
| fault_pull_low | output | 1 | Open-drain enable, 1 = drive the fault pad low |

## Verification
Suppose the recovery timer failed to reset on a reasserted trip, or started counting while the trip was still present. That fault would show at the ports as an inhibit window too short by the lost count. It appears on the very edge the latch clears, within `CLR_CYC` cycles of the trip falling, so the bench measures every window length exactly, against w − T + CLR for trips and p for enable lows. An off-by-one in either filter counter would accept a pulse one cycle too short, or would stretch every window by one cycle. Undervoltage is combinational, so any stray register in that path shows one cycle late at the first sample after `supply_ok` changes.

// File: rtl/oc_uv_fault_pkg.sv
package oc_uv_fault_pkg;

  typedef enum logic [1:0] {
    FILT_SYMMETRIC = 2'd0,  // both edges filtered
    FILT_RISE_ONLY = 2'd1   // rise filtered, fall passes at once
  } filt_mode_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/level_filter.sv
module level_filter
  import oc_uv_fault_pkg::*;
#(
  parameter int unsigned LEN       = 4,
  parameter filt_mode_e  MODE      = FILT_SYMMETRIC,
  parameter bit          RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  localparam int unsigned CW = cnt_width(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;
  logic          fast_drop;

  generate
    if (MODE == FILT_RISE_ONLY) begin : g_rise_only
      assign fast_drop = out_q & ~din;
      // R1: a trip sampled low removes acceptance on the same edge
      p_fast_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !din |=> !out_q);
    end else begin : g_symmetric
      assign fast_drop = 1'b0;
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (din == out_q) begin
      cnt_d = '0;
    end else if (fast_drop) begin
      out_d = 1'b0;
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      out_d = din;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= RESET_VAL;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign dout = out_q;

  // R1: a rising output is only ever caused by a high input
  p_accept_needs_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(din));

  // R8: a falling output in symmetric mode follows a low input
  p_drop_needs_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_q) |-> !$past(din));

endmodule

// File: rtl/oc_trip_latch.sv
module oc_trip_latch
  import oc_uv_fault_pkg::*;
#(
  parameter int unsigned CLR_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_raw,
  input  logic trip_acc,
  output logic latched
);

  localparam int unsigned TW = cnt_width(CLR_CYC);
  localparam logic [TW-1:0] TMR_LAST = TW'(CLR_CYC - 1);

  logic          latch_q, latch_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_en;
  logic          recovering;

  assign recovering = latch_q & ~trip_acc & ~trip_raw;
  assign tmr_en     = latch_q | trip_acc | (tmr_q != '0);

  always_comb begin
    latch_d = latch_q;
    tmr_d   = tmr_q;
    if (trip_acc) begin
      latch_d = 1'b1;
      tmr_d   = '0;
    end else if (recovering) begin
      if (tmr_q == TMR_LAST) begin
        latch_d = 1'b0;
        tmr_d   = '0;
      end else begin
        tmr_d = tmr_q + TW'(1);
      end
    end else begin
      tmr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      tmr_q   <= '0;
    end else if (tmr_en) begin
      latch_q <= latch_d;
      tmr_q   <= tmr_d;
    end
  end

  assign latched = latch_q;

  // R2: acceptance always leaves the latch set
  p_set_dominant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trip_acc |=> latch_q);

  // R3: timer discharged while the raw trip is present
  p_timer_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && trip_raw) |=> (tmr_q == '0));

  // R3: timer advances by exactly one per quiet cycle during recovery
  p_timer_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (recovering && tmr_q != TMR_LAST) |=> (tmr_q == $past(tmr_q) + TW'(1)));

  // R4: release only from a full timer with the trip gone
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_q) |-> ($past(tmr_q) == TMR_LAST && !$past(trip_raw)));

endmodule

// File: rtl/oc_uv_fault_ctl.sv
module oc_uv_fault_ctl
  import oc_uv_fault_pkg::*;
#(
  parameter int unsigned TRIP_FILT_CYC = 58,
  parameter int unsigned EN_FILT_CYC   = 75,
  parameter int unsigned CLR_CYC       = 475000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_in,
  input  logic supply_ok,
  input  logic enable_in,
  output logic gate_inhibit,
  output logic fault_pull_low
);

  logic rst_int_n;
  logic trip_acc;
  logic en_acc;
  logic oc_latched;
  logic uv_fault;

  rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  level_filter #(
    .LEN       (TRIP_FILT_CYC),
    .MODE      (FILT_RISE_ONLY),
    .RESET_VAL (1'b0)
  ) u_trip_filt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (trip_in),
    .dout  (trip_acc)
  );

  level_filter #(
    .LEN       (EN_FILT_CYC),
    .MODE      (FILT_SYMMETRIC),
    .RESET_VAL (1'b0)
  ) u_en_filt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (enable_in),
    .dout  (en_acc)
  );

  oc_trip_latch #(
    .CLR_CYC (CLR_CYC)
  ) u_latch (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .trip_raw (trip_in),
    .trip_acc (trip_acc),
    .latched  (oc_latched)
  );

  assign uv_fault       = ~supply_ok;
  assign fault_pull_low = oc_latched | uv_fault;
  assign gate_inhibit   = oc_latched | uv_fault | ~en_acc;

  // R6: undervoltage forces both outputs active
  p_uv_forces_off_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !supply_ok |-> (gate_inhibit && fault_pull_low));

  // R8: enable path never raises the fault flag
  p_en_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (supply_ok && !oc_latched && !en_acc) |-> !fault_pull_low);

  // R9: inhibit stays asserted until the enable has been accepted
  p_inhibit_until_en_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en_acc |-> gate_inhibit);

endmodule

// File: tb/sim_oc_uv_fault_ctl.sv
`timescale 1ns/1ps
module sim_oc_uv_fault_ctl;

  localparam int T   = 4;
  localparam int E   = 3;
  localparam int CLR = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic trip_in, supply_ok, enable_in;
  logic gate_inhibit, fault_pull_low;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  oc_uv_fault_ctl #(
    .TRIP_FILT_CYC (T),
    .EN_FILT_CYC   (E),
    .CLR_CYC       (CLR)
  ) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .trip_in        (trip_in),
    .supply_ok      (supply_ok),
    .enable_in      (enable_in),
    .gate_inhibit   (gate_inhibit),
    .fault_pull_low (fault_pull_low)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt_inh, cnt_flt;
    rst_n = 1'b0; trip_in = 1'b0; supply_ok = 1'b0; enable_in = 1'b1;
    tick(3);
    // R9 reset state
    check(gate_inhibit == 1'b1, "R9 inhibit in reset", gate_inhibit, 1);
    check(fault_pull_low == 1'b1, "R9/R6 flag with uv in reset", fault_pull_low, 1);
    supply_ok = 1'b1;
    #1;
    check(fault_pull_low == 1'b0, "R9 latch clear in reset", fault_pull_low, 0);
    check(gate_inhibit == 1'b1, "R9 inhibit before enable accepted", gate_inhibit, 1);
    @(negedge clk); rst_n = 1'b1;
    tick(1);
    check(gate_inhibit == 1'b1, "R9 inhibit just after reset", gate_inhibit, 1);
    tick(10);
    check(gate_inhibit == 1'b0, "R9 enable accepted", gate_inhibit, 0);

    // R1 R2 R3 R4 sweep of trip widths
    for (int w = 1; w <= T + 4; w++) begin
      cnt_inh = 0; cnt_flt = 0;
      trip_in = 1'b1;
      for (int i = 1; i <= w + T + CLR + 5; i++) begin
        tick(1);
        if (i == w) trip_in = 1'b0;
        if (gate_inhibit) cnt_inh++;
        if (fault_pull_low) cnt_flt++;
      end
      if (w < T) begin
        check(cnt_inh == 0, "R1 short trip ignored", cnt_inh, 0);
      end else begin
        check(cnt_inh == w - T + CLR, "R4 inhibit window", cnt_inh, w - T + CLR);
        check(cnt_flt == w - T + CLR, "R2/R3 fault window", cnt_flt, w - T + CLR);
      end
      check(gate_inhibit == 1'b0 && fault_pull_low == 1'b0, "R4 released",
            {gate_inhibit, fault_pull_low}, 0);
    end

    // R5 timer restart by a short reasserted trip
    trip_in = 1'b1; tick(T + 2);
    trip_in = 1'b0; tick(5);
    check(gate_inhibit == 1'b1, "R5 latched before glitch", gate_inhibit, 1);
    trip_in = 1'b1; tick(1);
    trip_in = 1'b0;
    tick(CLR - 1);
    check(gate_inhibit == 1'b1, "R5 timer restarted", gate_inhibit, 1);
    tick(1);
    check(gate_inhibit == 1'b0, "R5 release after full count", gate_inhibit, 0);

    // R6 undervoltage, not latched
    supply_ok = 1'b0; #1;
    check(gate_inhibit && fault_pull_low, "R6 uv immediate", {gate_inhibit, fault_pull_low}, 3);
    tick(3);
    supply_ok = 1'b1; #1;
    check(!gate_inhibit && !fault_pull_low, "R6 uv not latched", {gate_inhibit, fault_pull_low}, 0);

    // R7 OR of latch and uv
    @(negedge clk);
    trip_in = 1'b1; tick(T + 1);
    supply_ok = 1'b0; tick(1);
    supply_ok = 1'b1; #1;
    check(fault_pull_low == 1'b1, "R7 latch keeps flag after uv", fault_pull_low, 1);
    trip_in = 1'b0; tick(CLR + 2);
    check(fault_pull_low == 1'b0, "R7 flag clear", fault_pull_low, 0);

    // R8 enable low-pulse sweep
    for (int p = 1; p <= E + 3; p++) begin
      cnt_inh = 0; cnt_flt = 0;
      enable_in = 1'b0;
      for (int i = 1; i <= p + 2 * E + 4; i++) begin
        tick(1);
        if (i == p) enable_in = 1'b1;
        if (gate_inhibit) cnt_inh++;
        if (fault_pull_low) cnt_flt++;
      end
      check(cnt_inh == ((p >= E) ? p : 0), "R8 enable window", cnt_inh, (p >= E) ? p : 0);
      check(cnt_flt == 0, "R8 enable leaves flag", cnt_flt, 0);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule